// File: doc/BRIEF.md
# Interleaved Multiphase PWM Generator

This block is the digital modulator of a multiphase buck converter. A single free-running count sets one switching frequency shared by four PWM outputs. Each output compares its own phase-shifted view of that count, its carrier, against a common duty value. The phase shifts spread the active channels evenly across the switching period, so their pulses start and end in a fixed staggered sequence. That sequence lowers the combined ripple at the converter's input and output.

Two configuration straps set how many phases are in use: two, three or four. The straps are captured while reset is held. Channels that are not in use stay low. The duty value is clamped so that no pulse ever covers a whole period.

Top module: `ilv_pwm`

## Requirements
- R1: While `rst_ni` is low, all four outputs are low and the internal count is zero. The first clock edge with `rst_ni` high produces the pulse pattern for count value 0. At that value, the first channel in the firing order goes high whenever the clamped duty is nonzero.
- R2: The phase count N is captured only while reset is asserted. `strap_two_i` high gives N = 2, and it takes priority over `strap_three_i`. Otherwise `strap_three_i` high gives N = 3, and with neither strap high N = 4. Strap changes after reset is released have no effect on the outputs.
- R3: A channel whose number is greater than N is driven low at all times.
- R4: The shared count runs 0, 1, ..., P-1 and then wraps to 0, where P = max(`period_i`, 4). The count advances one step per clock. Each output is registered and shows, one clock later, the comparison made on the count value of the previous cycle.
- R5: Let step = floor(P / N). Channel k (k = 1..N, bit k-1 of `pwm_o`) has offset (N-k)*step. Its carrier is (count - offset) mod P, and the output is high while the carrier is below the clamped duty D. As a result, channel N starts and ends its pulse first, and channel 1 starts and ends its pulse last. The gap from channel 1 back to channel N is step plus the remainder P mod N.
- R6: The clamped duty is D = min(`duty_i`, P-1). With `duty_i` = 0 every output stays low. Over any window of P consecutive cycles, an active channel is high for exactly D cycles, so it is never high for a whole period.
- R7: For 0 < D < P, the falling edges of the same channel are exactly P clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low; straps are sampled while low |
| period_i | input | W | Switching period in clock cycles (values below 4 act as 4) |
| duty_i | input | W | Duty compare value, in cycles of high time per period |
| strap_three_i | input | 1 | High selects three-phase operation |
| strap_two_i | input | 1 | High selects two-phase operation (wins over `strap_three_i`) |
| pwm_o | output | 4 | PWM outputs; bit k-1 is channel k |

## Verification
Every output change takes effect one clock after the count value that causes it. The bench keeps its own reference count, which is zero at reset release and advances at each rising edge. At that edge the bench computes the expected pattern from the count value held before the edge, then compares it with the outputs at the following falling edge. The first comparison after reset release therefore checks the pattern for count 0. The falling-edge spacing and the high-time total over one period are measured in these same falling-edge samples.

// File: rtl/ilv_pwm_pkg.sv
package ilv_pwm_pkg;

    localparam int NUM_CH     = 4;
    localparam int MIN_PERIOD = 4;

    typedef enum logic [1:0] {
        MODE_4PH = 2'd0,
        MODE_3PH = 2'd1,
        MODE_2PH = 2'd2
    } phase_mode_e;

    // Two-phase strap dominates: with channel 3 unused, channel 4 is unused too.
    function automatic phase_mode_e decode_straps(input logic three, input logic two);
        if (two)        return MODE_2PH;
        else if (three) return MODE_3PH;
        else            return MODE_4PH;
    endfunction

    function automatic logic [2:0] phase_count(input phase_mode_e mode);
        case (mode)
            MODE_2PH: return 3'd2;
            MODE_3PH: return 3'd3;
            default:  return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/ilv_pwm_phase_map.sv
module ilv_pwm_phase_map
    import ilv_pwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]              period_i,
    input  logic [2:0]                nph_i,
    output logic [NUM_CH-1:0][W-1:0]  offset_o,
    output logic [NUM_CH-1:0]         active_o
);

    logic [W-1:0] step;

    // Integer share of the period per phase; the remainder falls to channel 1's gap.
    always_comb begin
        case (nph_i)
            3'd2:    step = period_i >> 1;
            3'd3:    step = period_i / W'(3);
            default: step = period_i >> 2;
        endcase
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_off
        logic [2:0] rank;
        assign active_o[g] = (3'(g + 1) <= nph_i);
        assign rank        = nph_i - 3'(g + 1);
        assign offset_o[g] = active_o[g] ? W'(step * W'(rank)) : '0;
    end

endmodule

// File: rtl/ilv_pwm_slice.sv
module ilv_pwm_slice #(
    parameter int W = 8
) (
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] period_i,
    input  logic [W-1:0] offset_i,
    input  logic [W-1:0] duty_i,
    input  logic         active_i,
    output logic         pwm_o
);

    logic [W-1:0] carrier;

    always_comb begin
        if (cnt_i >= offset_i) carrier = cnt_i - offset_i;
        else                   carrier = cnt_i + (period_i - offset_i);
        pwm_o = active_i && (carrier < duty_i);
    end

endmodule

// File: rtl/ilv_pwm.sv
module ilv_pwm
    import ilv_pwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] period_i,
    input  logic [W-1:0] duty_i,
    input  logic         strap_three_i,
    input  logic         strap_two_i,
    output logic [3:0]   pwm_o
);

    typedef struct packed {
        logic [W-1:0]      cnt;
        phase_mode_e       mode;
        logic [NUM_CH-1:0] pwm;
    } state_t;

    state_t state_d, state_q;

    logic [W-1:0]             p_eff;
    logic [W-1:0]             p_last;
    logic [W-1:0]             duty_c;
    logic [2:0]               nph;
    logic [NUM_CH-1:0][W-1:0] offsets;
    logic [NUM_CH-1:0]        active;
    logic [NUM_CH-1:0]        slice_pwm;

    assign p_eff  = (period_i < W'(MIN_PERIOD)) ? W'(MIN_PERIOD) : period_i;
    assign p_last = p_eff - W'(1);
    assign duty_c = (duty_i > p_last) ? p_last : duty_i;
    assign nph    = phase_count(state_q.mode);

    ilv_pwm_phase_map #(.W(W)) u_map (
        .period_i (p_eff),
        .nph_i    (nph),
        .offset_o (offsets),
        .active_o (active)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        ilv_pwm_slice #(.W(W)) u_slice (
            .cnt_i    (state_q.cnt),
            .period_i (p_eff),
            .offset_i (offsets[g]),
            .duty_i   (duty_c),
            .active_i (active[g]),
            .pwm_o    (slice_pwm[g])
        );
    end

    always_comb begin
        state_d     = state_q;
        state_d.cnt = (state_q.cnt >= p_last) ? '0 : state_q.cnt + W'(1);
        state_d.pwm = slice_pwm;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '{cnt: '0, mode: decode_straps(strap_three_i, strap_two_i), pwm: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assign pwm_o = state_q.pwm;

endmodule

// File: rtl/ilv_pwm_chk.sv
module ilv_pwm_chk #(
    parameter int W = 8
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic [W-1:0] period_i,
    input logic [W-1:0] duty_i,
    input logic         strap_three_i,
    input logic         strap_two_i,
    input logic [3:0]   pwm_o
);

    logic         two_q;
    logic         three_q;
    logic [W:0]   hi_run_q;
    logic [W:0]   p_chk;

    assign p_chk = (period_i < W'(4)) ? (W + 1)'(4) : {1'b0, period_i};

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            two_q    <= strap_two_i;
            three_q  <= strap_three_i & ~strap_two_i;
            hi_run_q <= '0;
        end else begin
            hi_run_q <= pwm_o[0] ? hi_run_q + (W + 1)'(1) : '0;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk_i)
        !rst_ni |=> (pwm_o == 4'b0000)); // R1

    AST_TWO_PH_UPPER_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        two_q |-> (pwm_o[3:2] == 2'b00)); // R3

    AST_THREE_PH_TOP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        three_q |-> !pwm_o[3]); // R3

    AST_ZERO_DUTY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (duty_i == '0) |=> (pwm_o == 4'b0000)); // R6

    AST_NO_FULL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwm_o[0] |-> (hi_run_q < p_chk - (W + 1)'(1))); // R6

endmodule

bind ilv_pwm ilv_pwm_chk #(.W(W)) u_chk (.*);

// File: tb/ilv_pwm_bench.sv
`timescale 1ns/1ps
module ilv_pwm_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] period = 8'd8;
    logic [W-1:0] duty = 8'd0;
    logic         s_three = 1'b0;
    logic         s_two = 1'b0;
    logic [3:0]   pwm;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    ilv_pwm #(.W(W)) u_ilv_pwm (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .period_i      (period),
        .duty_i        (duty),
        .strap_three_i (s_three),
        .strap_two_i   (s_two),
        .pwm_o         (pwm)
    );

    function automatic logic [3:0] model(int cnt, int p, int n, int d);
        logic [3:0] r = 4'b0000;
        int step = p / n;
        for (int k = 1; k <= 4; k++) begin
            if (k <= n) begin
                int off = (n - k) * step;
                int car = (cnt >= off) ? cnt - off : cnt + p - off;
                r[k-1] = (car < d);
            end
        end
        return r;
    endfunction

    task automatic check_int(string tag, int got, int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic run_cfg(bit three, bit two, int n, int per, int dsel);
        int p = (per < 4) ? 4 : per;
        int dv;
        int d;
        int cnt = 0;
        int last_fall = -1;
        int hi_cnt = 0;
        logic [3:0] exp;
        logic prev0 = 1'b0;
        case (dsel)
            0: dv = 0;
            1: dv = 1;
            2: dv = p / 2;
            3: dv = p - 1;
            4: dv = p;
            default: dv = 255;
        endcase
        d = (dv > p - 1) ? p - 1 : dv;

        @(negedge clk);
        rst_n = 1'b0; s_three = three; s_two = two;
        period = W'(per); duty = W'(dv);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_int("R1 reset outputs", int'(pwm), 0);
        end
        rst_n = 1'b1;
        // R2: strap changes after release must be ignored
        s_three = ~three; s_two = ~two;

        for (int c = 0; c < 2 * p + 3; c++) begin
            @(posedge clk);
            exp = model(cnt, p, n, d);
            cnt = (cnt >= p - 1) ? 0 : cnt + 1;
            @(negedge clk);
            for (int k = 0; k < 4; k++) begin
                string tag;
                if (c == 0)       tag = "R1 R4 first cycle";
                else if (k >= n)  tag = "R3 inactive";
                else if (d == 0)  tag = "R6 zero duty";
                else              tag = "R2 R5 phase";
                check_int($sformatf("%s ch%0d n%0d p%0d d%0d c%0d", tag, k + 1, n, p, d, c),
                          int'(pwm[k]), int'(exp[k]));
            end
            if (c < p && pwm[0]) hi_cnt++;
            if (c == p - 1)
                check_int($sformatf("R6 high cycles per period p%0d d%0d", p, d), hi_cnt, d);
            if (prev0 && !pwm[0]) begin
                if (last_fall >= 0)
                    check_int($sformatf("R7 fall spacing p%0d d%0d", p, d), c - last_fall, p);
                last_fall = c;
            end
            prev0 = pwm[0];
        end
    endtask

    initial begin
        int pers[4] = '{1, 5, 7, 12};
        for (int m = 0; m < 4; m++) begin
            bit t3 = (m == 1) || (m == 3);
            bit t2 = (m >= 2);
            int n  = t2 ? 2 : (t3 ? 3 : 4);
            for (int pi = 0; pi < 4; pi++)
                for (int ds = 0; ds < 6; ds++)
                    run_cfg(t3, t2, n, pers[pi], ds);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule